// File: doc/BRIEF.md
# 1-Wire Slave Bit-Timing Interface

This block is the physical-layer slave on a single-wire open-drain bus. It runs on a system clock and counts time with a one-microsecond tick enable. It watches the bus through a synchroniser and a glitch filter, and it controls the line through an active-low pulldown enable. The master starts every exchange with a falling edge. That edge restarts the slave's own microsecond timer, and the timer alone decides when a write bit is sampled and how long a read 0 is held.

A continuous low of 480 µs or more is a reset. The slave reports the reset to the upper layer. When the master releases the line, the slave waits a short delay and then answers with a presence pulse. The upper layer sees three things: a reset strobe, a strobe carrying each received bit, and an acknowledge when a bit it offered for transmission is used in a read slot. If no bit is offered when a slot starts, the slot is decoded as a write slot.

Top module: `ow_slave_phy`

## Requirements
- R1: After rst_ni deasserts and while no slot or presence is active, drive_n_o is 1 (bus released) and none of the strobes pulse.
- R2: A bus low lasting RST_US (480) µs or longer gives exactly one single-cycle rst_det_o pulse. A low of 400 µs gives none.
- R3: After a reset, once the bus has returned high, drive_n_o stays 1 for PD_WAIT_US (30) µs, then stays 0 for PD_LEN_US (120) µs, then returns to 1.
- R4: In a write slot where the master holds the line low for 2–15 µs, one rx_valid_o pulse is reported, with rx_bit_o = 1.
- R5: In a write slot where the master holds the line low for 60–120 µs, one rx_valid_o pulse is reported, with rx_bit_o = 0. The bit is the bus level sampled SAMPLE_US (30) µs after the falling edge.
- R6: If tx_req_i = 1 and tx_bit_i = 0 when a slot's falling edge is detected, the slot is a read slot. tx_ack_o pulses once, drive_n_o is 0 at 8 µs, and the line is released again by 20 µs after the edge.
- R7: A read slot with tx_bit_i = 1 never drives the line. Read slots of either value produce no rx_valid_o pulse.
- R8: A slot that starts while tx_req_i = 0 gives no tx_ack_o pulse and is decoded as a write slot.
- R9: A bus low lasting fewer than FILT_LEN clock cycles starts no slot and produces no strobe.
- R10: The slave pulls the line low only during a presence pulse or during the hold of a read 0.
- R11: A slot whose low time reaches RST_US becomes a reset and reports no received bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| bus_i | input | 1 | Bus level as seen at the pin |
| drive_n_o | output | 1 | Pulldown enable, active low (0 pulls the line low) |
| rst_det_o | output | 1 | One-cycle strobe when a bus reset is detected |
| rx_valid_o | output | 1 | One-cycle strobe when a write-slot bit is received |
| rx_bit_o | output | 1 | Received bit value, valid with rx_valid_o |
| tx_req_i | input | 1 | Upper layer has a bit ready to send |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| tx_ack_o | output | 1 | One-cycle strobe when the offered bit is consumed |

## Verification
The assertions assume a master that respects slot timing. There is no new falling edge before the current slot's sample point, and at least one microsecond of recovery separates slots. The assertions also assume that tx_bit_i is stable whenever tx_req_i is asserted at a falling edge. The stimulus follows these rules: each slot runs at least 100 µs, a recovery gap follows it, and the offered bit is set before the master pulls the line low. The only out-of-rule inputs the stimulus applies are a one-clock glitch and over-long lows, and these target the filter and reset-promotion behaviour.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RSTLOW,
    ST_PDWAIT,
    ST_PDLOW
  } ow_state_e;
endpackage

// File: rtl/ow_in_filter.sv
module ow_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FW-1:0]          run_q;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // level must differ for FILT_LEN consecutive clocks before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b1;
      run_q  <= '0;
    end else if (smp == filt_o) begin
      run_q <= '0;
    end else if (run_q == FW'(FILT_LEN - 1)) begin
      filt_o <= smp;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  p_filt_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_o != $past(filt_o)) |-> ($past(smp) == filt_o));
endmodule

// File: rtl/ow_us_counter.sv
module ow_us_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (tick_i && ~&cnt_o)   cnt_o <= cnt_o + 1'b1;
  end

  p_cnt_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o && !clr_i) |=> &cnt_o);
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
  import ow_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int RST_US      = 480,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 15,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LEN_US   = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic bus_i,
  output logic drive_n_o,
  output logic rst_det_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  input  logic tx_req_i,
  input  logic tx_bit_i,
  output logic tx_ack_o
);
  localparam int CW = $clog2(RST_US + 1) + 1;

  ow_state_e st_q;
  logic bus_f, bus_q, fall, rise;
  logic cnt_clr, drive_low;
  logic rd_q, txb_q, sampled_q, rxb_q;
  logic [CW-1:0] cnt;

  ow_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (bus_i),
    .filt_o(bus_f)
  );

  ow_us_counter #(.W(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .tick_i(tick_us_i),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= 1'b1;
    else         bus_q <= bus_f;
  end

  assign fall = bus_q & ~bus_f;
  assign rise = ~bus_q & bus_f;

  assign cnt_clr = (st_q == ST_IDLE   && fall) ||
                   (st_q == ST_RSTLOW && rise) ||
                   (st_q == ST_PDWAIT && cnt >= CW'(PD_WAIT_US));

  assign drive_low = (st_q == ST_PDLOW) ||
                     (st_q == ST_SLOT && rd_q && !txb_q && cnt < CW'(HOLD_US));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      drive_n_o  <= 1'b1;
      rst_det_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
      tx_ack_o   <= 1'b0;
      rd_q       <= 1'b0;
      txb_q      <= 1'b1;
      sampled_q  <= 1'b0;
      rxb_q      <= 1'b0;
    end else begin
      drive_n_o  <= ~drive_low;
      rst_det_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_ack_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fall) begin
          st_q      <= ST_SLOT;
          sampled_q <= 1'b0;
          rd_q      <= tx_req_i;
          txb_q     <= tx_req_i ? tx_bit_i : 1'b1;
          tx_ack_o  <= tx_req_i;
        end
        ST_SLOT: begin
          if (!bus_f && cnt >= CW'(RST_US)) begin
            rst_det_o <= 1'b1;               // long slot promoted to reset
            st_q      <= ST_RSTLOW;
          end else if (!sampled_q) begin
            if (cnt >= CW'(SAMPLE_US)) begin
              sampled_q <= 1'b1;
              rxb_q     <= bus_f;
            end
          end else if (bus_f) begin
            st_q       <= ST_IDLE;
            rx_valid_o <= !rd_q;
            if (!rd_q) rx_bit_o <= rxb_q;
          end
        end
        ST_RSTLOW: if (rise) st_q <= ST_PDWAIT;
        ST_PDWAIT: if (cnt >= CW'(PD_WAIT_US)) st_q <= ST_PDLOW;
        ST_PDLOW:  if (cnt >= CW'(PD_LEN_US))  st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> drive_n_o);

  p_rst_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_o |=> !rst_det_o);

  p_rst_on_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_o |-> !$past(bus_f));

  p_ack_at_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_o |-> ($past(fall) && $past(tx_req_i)));

  p_rx_not_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !$past(rd_q));

  p_drive_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_n_o |-> ($past(st_q) == ST_PDLOW ||
                    ($past(st_q) == ST_SLOT && $past(rd_q) && !$past(txb_q))));

  p_rx_no_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (!rst_det_o && $past(bus_f)));
endmodule

// File: tb/ow_slave_phy_tb.sv
module ow_slave_phy_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_low = 1'b0;
  logic tx_req = 1'b0, tx_bit = 1'b1;
  logic [1:0] tdiv = '0;
  logic tick_us, drive_n, rst_det, rx_valid, rx_bit, tx_ack;
  wire  bus = !master_low && drive_n;

  int n_chk = 0, n_fail = 0;
  int c_rst = 0, c_rx = 0, c_ack = 0;
  logic last_bit = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick_us = (tdiv == 2'd3);

  ow_slave_phy u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_us_i(tick_us), .bus_i(bus),
    .drive_n_o(drive_n), .rst_det_o(rst_det), .rx_valid_o(rx_valid),
    .rx_bit_o(rx_bit), .tx_req_i(tx_req), .tx_bit_i(tx_bit), .tx_ack_o(tx_ack)
  );

  always @(posedge clk) begin
    if (rst_det) c_rst <= c_rst + 1;
    if (rx_valid) begin c_rx <= c_rx + 1; last_bit <= rx_bit; end
    if (tx_ack) c_ack <= c_ack + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // low_us, tx_req, tx_bit, exp_rx, exp_bit, exp_drive_low_at_8us
  typedef struct packed {
    logic [9:0] low_us;
    logic req, tbit, exp_rx, exp_bit, exp_d8;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{10'd5,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4, R8
    '{10'd2,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4
    '{10'd14,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    '{10'd80,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    '{10'd110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5
    '{10'd2,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R6, R10
    '{10'd2,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R7
    '{10'd400, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}   // R2 no reset below threshold
  };

  initial begin
    wait_us(3000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic presence_check(input string tag);
    for (int t = 0; t < 250; t++) begin
      if (t == 16)  chk(drive_n == 1'b1, {tag, " R3 wait"},    drive_n, 1);
      if (t == 35)  chk(drive_n == 1'b0, {tag, " R3 low"},     drive_n, 0);
      if (t == 145) chk(drive_n == 1'b0, {tag, " R3 low end"}, drive_n, 0);
      if (t == 160) chk(drive_n == 1'b1, {tag, " R3 release"}, drive_n, 1);
      wait_us(1);
    end
  endtask

  initial begin
    int rx0, rst0, ack0;
    logic d8, d20;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    wait_us(10);
    // R1 reset state
    chk(drive_n == 1'b1, "R1 drive", drive_n, 1);
    chk(c_rst + c_rx + c_ack == 0, "R1 strobes", c_rst + c_rx + c_ack, 0);

    for (int i = 0; i < NV; i++) begin
      tx_req = VEC[i].req;
      tx_bit = VEC[i].tbit;
      rx0 = c_rx; rst0 = c_rst; ack0 = c_ack;
      d8 = 1'b1; d20 = 1'b1;
      master_low = 1'b1;
      for (int t = 0; t < 110 || t < int'(VEC[i].low_us) + 10; t++) begin
        if (t == int'(VEC[i].low_us)) master_low = 1'b0;
        if (t == 3) tx_req = 1'b0;
        if (t == 8) d8 = drive_n;
        if (t == 20) d20 = drive_n;
        wait_us(1);
      end
      chk(c_rx - rx0 == int'(VEC[i].exp_rx), $sformatf("v%0d R4/R5/R7 rx count", i),
          c_rx - rx0, VEC[i].exp_rx);
      if (VEC[i].exp_rx)
        chk(last_bit == VEC[i].exp_bit, $sformatf("v%0d R4/R5 rx bit", i), last_bit, VEC[i].exp_bit);
      chk(c_ack - ack0 == int'(VEC[i].req), $sformatf("v%0d R6/R8 ack", i), c_ack - ack0, VEC[i].req);
      chk(d8 == !VEC[i].exp_d8, $sformatf("v%0d R6/R7/R10 drive8", i), d8, !VEC[i].exp_d8);
      chk(d20 == 1'b1, $sformatf("v%0d R6 drive20", i), d20, 1);
      chk(c_rst == rst0, $sformatf("v%0d R2 no reset", i), c_rst - rst0, 0);
    end

    // R2/R3: reset pulse then presence
    rst0 = c_rst; rx0 = c_rx;
    master_low = 1'b1;
    wait_us(500);
    master_low = 1'b0;
    chk(c_rst - rst0 == 1, "R2 reset strobe", c_rst - rst0, 1);
    presence_check("rst500");

    // R11: very long low slot becomes reset with no bit
    rst0 = c_rst; rx0 = c_rx;
    master_low = 1'b1;
    wait_us(700);
    master_low = 1'b0;
    chk(c_rst - rst0 == 1, "R11 reset", c_rst - rst0, 1);
    presence_check("rst700");
    chk(c_rx == rx0, "R11 no rx", c_rx - rx0, 0);

    // R9: one-clock glitch
    rx0 = c_rx; ack0 = c_ack;
    tx_req = 1'b1; tx_bit = 1'b0;
    @(negedge clk) master_low = 1'b1;
    @(negedge clk) master_low = 1'b0;
    wait_us(100);
    tx_req = 1'b0;
    chk(c_rx == rx0, "R9 glitch rx", c_rx - rx0, 0);
    chk(c_ack == ack0, "R9 glitch ack", c_ack - ack0, 0);
    chk(drive_n == 1'b1, "R9 R1 released", drive_n, 1);

    // write after presence still decodes (R5)
    rx0 = c_rx;
    master_low = 1'b1; wait_us(70); master_low = 1'b0; wait_us(40);
    chk(c_rx - rx0 == 1 && last_bit == 1'b0, "R5 post-presence", last_bit, 0);

    finish_run();
  end
endmodule